// File: doc/BRIEF.md
# Hashed Station Table Learning and Ageing Engine

This block keeps the station table that a forwarding lookup engine reads. A queue of observations comes in, each one a source station address (48 bits) and the ingress port it was seen on. For each observation the engine hashes the address to a bucket of the table and compares it with every way of that bucket. A known station gets a fresh timestamp, and its port is rewritten if it has moved. An unknown station takes a free way. When the bucket has no free way it replaces the way whose timestamp is the oldest.

A 10-bit time counter advances on a prescaled tick. While no observation is waiting, a background sweep walks the table one entry per cycle and clears the valid bit of any entry whose age has reached the programmed limit. The limit is set in whole minutes, from 1 to 6, through a small configuration write. The lookup engine reads entries through a combinational read port that uses the same index and entry layout.

Top module: `mac_learn_ager`

## Requirements
- R1: After reset every entry reads back invalid, the time output is 0, the drop count is 0, and the ageing limit is 1 minute.
- R2: Entry layout on the read port is bit 63 valid, bit 62 reserved (0), bits 61:58 port, bits 57:48 timestamp, bits 47:0 address. The entry index is bucket*WAYS+way. Bucket bit k is the XOR of every address bit i (i from 0 to 23) with i mod HASH_W equal to k. An address that is not yet in its bucket is written into the lowest-numbered invalid way with valid set, its port and the current time.
- R3: When the bucket of a new address has no invalid way, the way with the largest age (current time minus timestamp, modulo 1024) is overwritten. On equal ages the lowest way wins.
- R4: An address already present on the same port keeps its port and gets its timestamp set to the current time.
- R5: An address already present on a different port has its port replaced by the new port and its timestamp set to the current time. No second entry is created.
- R6: The time output increases by one every TICK_DIV clock cycles and wraps from 1023 to 0.
- R7: A configuration write loads the ageing limit in minutes, clamped to the range 1 to 6. The limit in ticks is minutes times TICKS_PER_MIN.
- R8: In every cycle in which the engine is idle and the queue is empty, the sweep visits one entry, moving through the indices in increasing order and wrapping at the end. A visited entry that is valid with age greater than or equal to the limit is invalidated. All other entries are left unchanged.
- R9: A waiting observation takes priority over the sweep. The engine pops it in one cycle and writes the table in the next, and the sweep does not advance in either cycle. With an empty queue, an observation appears in the table two clock edges after the edge that queued it.
- R10: Observations are processed in arrival order through a FIFO_DEPTH-entry queue. An observation that arrives while the queue holds FIFO_DEPTH entries is discarded, and the drop count increments, saturating at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Observation present this cycle |
| obs_mac | input | 48 | Observed source station address |
| obs_port | input | 4 | Port the observation arrived on |
| cfg_we | input | 1 | Load the ageing limit |
| cfg_minutes | input | 3 | Ageing limit in minutes (clamped to 1..6) |
| rd_idx | input | IDX_W | Entry index for the lookup read port |
| rd_entry | output | 64 | Entry at rd_idx, combinational |
| cur_time | output | 10 | Current time in ticks |
| drop_count | output | DROP_W | Discarded observations, saturating |

## Verification
Some properties are checked on every cycle. The time output never moves by more than one step. The drop count moves exactly when an observation meets a full queue. The ageing limit always stays within the 1 to 6 minute range. A waiting observation always sends an idle engine to its write state. The sweep index always advances in idle cycles with an empty queue. Replacement only ever happens in a bucket whose ways are all valid. The choices of which way is used, such as oldest-victim selection, tie-breaking, the exact expiry boundary, and which observations get dropped in a burst, depend on the table contents. Only the bench can show these, because its reference model tracks the whole table and is compared with the read port on every clock.

// File: rtl/mac_learn_pkg.sv
package mac_learn_pkg;

  localparam int MAC_W   = 48;
  localparam int PORT_W  = 4;
  localparam int TIME_W  = 10;
  localparam int ENTRY_W = 1 + 1 + PORT_W + TIME_W + MAC_W;

  localparam logic [2:0] MINUTES_LO = 3'd1;
  localparam logic [2:0] MINUTES_HI = 3'd6;

  typedef struct packed {
    logic                valid;
    logic                rsvd;
    logic [PORT_W-1:0]   port;
    logic [TIME_W-1:0]   stamp;
    logic [MAC_W-1:0]    mac;
  } entry_t;

  // Age in ticks, modulo the time counter range.
  function automatic logic [TIME_W-1:0] age_of(input logic [TIME_W-1:0] now,
                                               input logic [TIME_W-1:0] stamp);
    return now - stamp;
  endfunction

  // Minutes to ticks, with the minute count clamped to the legal range.
  function automatic logic [TIME_W-1:0] minutes_to_ticks(input logic [2:0] minutes,
                                                         input int unsigned tpm);
    logic [2:0] m;
    m = minutes;
    if (m < MINUTES_LO) m = MINUTES_LO;
    if (m > MINUTES_HI) m = MINUTES_HI;
    return TIME_W'(int'(m) * int'(tpm));
  endfunction

endpackage

// File: rtl/mac_learn_fifo.sv
module mac_learn_fifo #(
  parameter  int DEPTH = 4,
  parameter  int W     = 52,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_valid,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push_valid && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/mac_learn_timebase.sv
module mac_learn_timebase
  import mac_learn_pkg::*;
#(
  parameter  int TICK_DIV      = 8,
  parameter  int TICKS_PER_MIN = 16,
  localparam int PW            = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_minutes,
  output logic [TIME_W-1:0] now,
  output logic [TIME_W-1:0] limit
);

  logic [PW-1:0] presc;
  logic          tick;

  assign tick = (presc == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      now   <= '0;
    end else if (tick) begin
      presc <= '0;
      now   <= now + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit <= minutes_to_ticks(MINUTES_LO, TICKS_PER_MIN);
    else if (cfg_we) limit <= minutes_to_ticks(cfg_minutes, TICKS_PER_MIN);
  end

endmodule

// File: rtl/mac_learn_table.sv
module mac_learn_table
  import mac_learn_pkg::*;
#(
  parameter  int NBKT  = 8,
  parameter  int WAYS  = 4,
  localparam int NENT  = NBKT * WAYS,
  localparam int IDX_W = $clog2(NENT),
  localparam int BKT_W = (NBKT > 1) ? $clog2(NBKT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wr_idx,
  input  entry_t                  wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output entry_t                  rd_data,
  input  logic [IDX_W-1:0]        sw_idx,
  output entry_t                  sw_data,
  input  logic [BKT_W-1:0]        bkt_idx,
  output entry_t [WAYS-1:0]       bkt_data
);

  entry_t mem [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
  assign sw_data = mem[sw_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign bkt_data[w] = mem[IDX_W'(int'(bkt_idx) * WAYS + w)];
  end

endmodule

// File: rtl/mac_learn_ager.sv
module mac_learn_ager
  import mac_learn_pkg::*;
#(
  parameter  int HASH_W        = 3,
  parameter  int WAYS          = 4,
  parameter  int FIFO_DEPTH    = 4,
  parameter  int TICK_DIV      = 8,
  parameter  int TICKS_PER_MIN = 16,
  parameter  int DROP_W        = 16,
  localparam int NBKT          = 1 << HASH_W,
  localparam int NENT          = NBKT * WAYS,
  localparam int IDX_W         = $clog2(NENT),
  localparam int WAY_W         = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                obs_valid,
  input  logic [47:0]         obs_mac,
  input  logic [3:0]          obs_port,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_minutes,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [63:0]         rd_entry,
  output logic [9:0]          cur_time,
  output logic [DROP_W-1:0]   drop_count
);

  typedef enum logic {ST_IDLE, ST_LEARN} state_t;

  // Bucket hash: address bit i folds into hash bit (i mod HASH_W).
  function automatic logic [HASH_W-1:0] bucket_of(input logic [MAC_W-1:0] mac);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int i = 0; i < 24; i++) h[i % HASH_W] ^= mac[i];
    return h;
  endfunction

  state_t               state;
  logic [MAC_W-1:0]     req_mac;
  logic [PORT_W-1:0]    req_port;
  logic [IDX_W-1:0]     sweep_idx;
  logic [TIME_W-1:0]    now, limit;

  logic                 fifo_empty, fifo_full, fifo_pop;
  logic [MAC_W+PORT_W-1:0] fifo_head;

  entry_t               rd_data, sw_data, wr_data;
  entry_t [WAYS-1:0]    bkt_data;
  logic [HASH_W-1:0]    learn_bkt;
  logic                 tbl_we;
  logic [IDX_W-1:0]     tbl_widx;

  // Named internal events, used by the bound checker.
  logic                 st_idle, st_learn, idle_empty;
  logic                 hit_found, free_found;
  logic [WAY_W-1:0]     hit_way, free_way, old_way, sel_way;
  logic                 ev_refresh, ev_migrate, ev_insert, ev_evict, ev_expire;
  logic [WAYS-1:0]      bkt_valid;
  entry_t               sel_entry;

  mac_learn_fifo #(.DEPTH(FIFO_DEPTH), .W(MAC_W + PORT_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (obs_valid),
    .push_data  ({obs_mac, obs_port}),
    .pop        (fifo_pop),
    .head       (fifo_head),
    .empty      (fifo_empty),
    .full       (fifo_full)
  );

  mac_learn_timebase #(.TICK_DIV(TICK_DIV), .TICKS_PER_MIN(TICKS_PER_MIN)) u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_minutes (cfg_minutes),
    .now         (now),
    .limit       (limit)
  );

  mac_learn_table #(.NBKT(NBKT), .WAYS(WAYS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .wr_idx   (tbl_widx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .sw_idx   (sweep_idx),
    .sw_data  (sw_data),
    .bkt_idx  (learn_bkt),
    .bkt_data (bkt_data)
  );

  assign st_idle    = (state == ST_IDLE);
  assign st_learn   = (state == ST_LEARN);
  assign idle_empty = st_idle && fifo_empty;
  assign fifo_pop   = st_idle && !fifo_empty;
  assign learn_bkt  = bucket_of(req_mac);

  for (genvar w = 0; w < WAYS; w++) begin : g_valid
    assign bkt_valid[w] = bkt_data[w].valid;
  end

  // Way selection: matching way, else lowest free way, else oldest way.
  always_comb begin
    logic [TIME_W-1:0] old_age;
    hit_found  = 1'b0;
    hit_way    = '0;
    free_found = 1'b0;
    free_way   = '0;
    old_way    = '0;
    old_age    = age_of(now, bkt_data[0].stamp);
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_found && bkt_data[w].valid && bkt_data[w].mac == req_mac) begin
        hit_found = 1'b1;
        hit_way   = WAY_W'(w);
      end
      if (!free_found && !bkt_data[w].valid) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
      if (age_of(now, bkt_data[w].stamp) > old_age) begin
        old_age = age_of(now, bkt_data[w].stamp);
        old_way = WAY_W'(w);
      end
    end
    sel_way = hit_found ? hit_way : (free_found ? free_way : old_way);
  end

  assign sel_entry  = bkt_data[sel_way];
  assign ev_refresh = st_learn && hit_found && (sel_entry.port == req_port);
  assign ev_migrate = st_learn && hit_found && (sel_entry.port != req_port);
  assign ev_insert  = st_learn && !hit_found && free_found;
  assign ev_evict   = st_learn && !hit_found && !free_found;
  assign ev_expire  = idle_empty && sw_data.valid && (age_of(now, sw_data.stamp) >= limit);

  // Single table write port: learning owns it in ST_LEARN, the sweep otherwise.
  always_comb begin
    tbl_we   = 1'b0;
    tbl_widx = sweep_idx;
    wr_data  = sw_data;
    if (st_learn) begin
      tbl_we        = 1'b1;
      tbl_widx      = IDX_W'(int'(learn_bkt) * WAYS + int'(sel_way));
      wr_data       = sel_entry;
      wr_data.valid = 1'b1;
      wr_data.port  = req_port;
      wr_data.stamp = now;
      wr_data.mac   = req_mac;
    end else if (ev_expire) begin
      tbl_we        = 1'b1;
      wr_data.valid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_mac   <= '0;
      req_port  <= '0;
      sweep_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!fifo_empty) begin
            {req_mac, req_port} <= fifo_head;
            state               <= ST_LEARN;
          end else begin
            sweep_idx <= (sweep_idx == IDX_W'(NENT - 1)) ? '0 : sweep_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                drop_count <= '0;
    else if (obs_valid && fifo_full && !(&drop_count)) drop_count <= drop_count + 1'b1;
  end

  assign rd_entry = rd_data;
  assign cur_time = now;

endmodule

// File: rtl/mac_learn_ager_chk.sv
module mac_learn_ager_chk #(
  parameter int WAYS          = 4,
  parameter int IDX_W         = 5,
  parameter int DROP_W        = 16,
  parameter int TICKS_PER_MIN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              obs_valid,
  input logic [9:0]        cur_time,
  input logic [DROP_W-1:0] drop_count,
  input logic [9:0]        limit,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              st_idle,
  input logic              st_learn,
  input logic [IDX_W-1:0]  sweep_idx,
  input logic              ev_refresh,
  input logic              ev_migrate,
  input logic              ev_insert,
  input logic              ev_evict,
  input logic [WAYS-1:0]   bkt_valid
);

  assert_time_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_time == $past(cur_time) || cur_time == $past(cur_time) + 10'd1));

  assert_limit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit >= 10'(TICKS_PER_MIN)) && (limit <= 10'(6 * TICKS_PER_MIN)));

  assert_learn_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && !fifo_empty) |=> st_learn);

  assert_sweep_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && fifo_empty) |=> (sweep_idx != $past(sweep_idx)));

  assert_drop_counts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && fifo_full && !(&drop_count)) |=> (drop_count == $past(drop_count) + 1'b1));

  assert_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(obs_valid && fifo_full) |=> (drop_count == $past(drop_count)));

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_refresh, ev_migrate, ev_insert, ev_evict}));

  assert_evict_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |-> (&bkt_valid));

endmodule

bind mac_learn_ager mac_learn_ager_chk #(
  .WAYS(WAYS), .IDX_W(IDX_W), .DROP_W(DROP_W), .TICKS_PER_MIN(TICKS_PER_MIN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .obs_valid  (obs_valid),
  .cur_time   (cur_time),
  .drop_count (drop_count),
  .limit      (limit),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .st_idle    (st_idle),
  .st_learn   (st_learn),
  .sweep_idx  (sweep_idx),
  .ev_refresh (ev_refresh),
  .ev_migrate (ev_migrate),
  .ev_insert  (ev_insert),
  .ev_evict   (ev_evict),
  .bkt_valid  (bkt_valid)
);

// File: tb/mac_learn_ager_bench.sv
module mac_learn_ager_bench;

  localparam int HASH_W = 3;
  localparam int WAYS   = 4;
  localparam int FD     = 4;
  localparam int TD     = 8;
  localparam int TPM    = 16;
  localparam int NENT   = (1 << HASH_W) * WAYS;
  localparam int IDX_W  = $clog2(NENT);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              obs_valid = 1'b0;
  logic [47:0]       obs_mac = '0;
  logic [3:0]        obs_port = '0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_minutes = '0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [63:0]       rd_entry;
  logic [9:0]        cur_time;
  logic [15:0]       drop_count;

  always #2 clk = ~clk;

  mac_learn_ager #(.HASH_W(HASH_W), .WAYS(WAYS), .FIFO_DEPTH(FD), .TICK_DIV(TD),
                   .TICKS_PER_MIN(TPM), .DROP_W(16)) u_mac_learn_ager (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_mac(obs_mac),
    .obs_port(obs_port), .cfg_we(cfg_we), .cfg_minutes(cfg_minutes),
    .rd_idx(rd_idx), .rd_entry(rd_entry), .cur_time(cur_time), .drop_count(drop_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_valid [NENT];
  logic [3:0]  m_port  [NENT];
  logic [9:0]  m_stamp [NENT];
  logic [47:0] m_mac   [NENT];
  logic [51:0] m_q [$];
  int          m_busy, m_sidx, m_presc, m_limit, m_drops;
  logic [9:0]  m_time;
  logic [47:0] m_rmac;
  logic [3:0]  m_rport;

  function automatic int hash_of(input logic [47:0] mac);
    int h = 0;
    for (int c = 0; c * HASH_W < 24; c++) h ^= int'((mac[23:0] >> (c * HASH_W))) & ((1 << HASH_W) - 1);
    return h;
  endfunction

  function automatic int age_of(input logic [9:0] t, input logic [9:0] s);
    logic [9:0] d;
    d = t - s;
    return int'(d);
  endfunction

  function automatic int lim_of(input int m);
    if (m < 1) m = 1;
    if (m > 6) m = 6;
    return m * TPM;
  endfunction

  function automatic logic [63:0] m_entry(input int i);
    return {m_valid[i], 1'b0, m_port[i], m_stamp[i], m_mac[i]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) begin
      m_valid[i] = 0; m_port[i] = '0; m_stamp[i] = '0; m_mac[i] = '0;
    end
    m_q.delete();
    m_busy = 0; m_sidx = 0; m_presc = 0; m_drops = 0; m_time = '0;
    m_limit = lim_of(1);
  endtask

  task automatic model_learn();
    int base, w, best;
    base = hash_of(m_rmac) * WAYS;
    w = -1;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && m_valid[base+i] && m_mac[base+i] == m_rmac) w = i;
    for (int i = 0; i < WAYS; i++)
      if (w < 0 && !m_valid[base+i]) w = i;
    if (w < 0) begin
      best = -1;
      for (int i = 0; i < WAYS; i++)
        if (age_of(m_time, m_stamp[base+i]) > best) begin
          best = age_of(m_time, m_stamp[base+i]);
          w = i;
        end
    end
    m_valid[base+w] = 1; m_port[base+w] = m_rport;
    m_stamp[base+w] = m_time; m_mac[base+w] = m_rmac;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    int cnt0;
    bit do_pop;
    if (!rst_n) model_reset();
    else begin
      cnt0 = m_q.size();
      do_pop = 0;
      if (m_busy == 0) begin
        if (cnt0 > 0) begin
          {m_rmac, m_rport} = m_q[0];
          do_pop = 1;
          m_busy = 1;
        end else begin
          if (m_valid[m_sidx] && age_of(m_time, m_stamp[m_sidx]) >= m_limit) m_valid[m_sidx] = 0;
          m_sidx = (m_sidx + 1) % NENT;
        end
      end else begin
        model_learn();
        m_busy = 0;
      end
      if (do_pop) void'(m_q.pop_front());
      if (obs_valid) begin
        if (cnt0 < FD) m_q.push_back({obs_mac, obs_port});
        else if (m_drops < 65535) m_drops++;
      end
      if (cfg_we) m_limit = lim_of(int'(cfg_minutes));
      if (m_presc == TD - 1) begin m_presc = 0; m_time = m_time + 10'd1; end
      else m_presc++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit dir_rd = 0;
  int scan = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dir_rd) rd_idx = IDX_W'(scan);
      scan = (scan + 1) % NENT;
      #1;
      chk("R6 time", 64'(cur_time), 64'(m_time));
      chk("R10 drop count", 64'(drop_count), 64'(m_drops));
      chk("R2/R3/R4/R5/R8/R9 entry", rd_entry, m_entry(int'(rd_idx)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(input logic [47:0] mac, input logic [3:0] port);
    @(negedge clk);
    obs_valid = 1'b1; obs_mac = mac; obs_port = port;
    @(negedge clk);
    obs_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [63:0] e);
    dir_rd = 1;
    @(negedge clk);
    rd_idx = IDX_W'(idx);
    #1 e = rd_entry;
    dir_rd = 0;
  endtask

  task automatic find(input logic [47:0] mac, output int idx);
    logic [63:0] e;
    idx = -1;
    for (int i = 0; i < NENT; i++) begin
      rd(i, e);
      if (e[63] && e[47:0] == mac) idx = i;
    end
  endtask

  task automatic set_minutes(input logic [2:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_minutes = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [47:0] bmac(input int k);
    return {24'hC0FFEE, 24'(k * 9)};
  endfunction

  function automatic logic [47:0] emac(input int k);
    return {24'hE0E0E0, 24'(k)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [63:0] e;
    logic [9:0]  s0, t0;
    int          ix;
    localparam logic [47:0] A = 48'h020000_000001;  // bucket 1 -> index 4
    localparam logic [47:0] C = 48'h0A0B0C_000002;  // bucket 2 -> index 8
    localparam logic [47:0] D = 48'h0D0D0D_000003;  // bucket 3 -> index 12
    localparam logic [47:0] G = 48'h123456_000004;  // bucket 4 -> index 16

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1 time after reset", 64'(cur_time), 64'd0);
    chk("R1 drops after reset", 64'(drop_count), 64'd0);
    for (int i = 0; i < NENT; i++) begin
      rd(i, e);
      chk("R1 entry invalid after reset", 64'(e[63]), 64'd0);
    end

    // R2: first insertion goes to way 0 of its bucket
    send(A, 4'd2);
    idle(3);
    rd(4, e);
    chk("R2 valid", 64'(e[63]), 64'd1);
    chk("R2 port", 64'(e[61:58]), 64'd2);
    chk("R2 address", 64'(e[47:0]), 64'(A));
    s0 = e[57:48];

    // R4: same port refresh
    idle(40);
    send(A, 4'd2);
    idle(3);
    rd(4, e);
    chk("R4 port kept", 64'(e[61:58]), 64'd2);
    chk("R4 stamp moved forward", 64'(e[57:48] > s0), 64'd1);

    // R5: migration to another port, no duplicate
    send(A, 4'd9);
    idle(3);
    rd(4, e);
    chk("R5 port updated", 64'(e[61:58]), 64'd9);
    rd(5, e);
    chk("R5 no second entry", 64'(e[63]), 64'd0);

    // R3: fill bucket 0, refresh way 0, then one more address evicts way 1
    for (int k = 1; k <= 4; k++) begin
      send(bmac(k), 4'(k));
      idle(12);
    end
    send(bmac(1), 4'd1);
    idle(12);
    send(bmac(5), 4'd5);
    idle(3);
    rd(0, e); chk("R3 way0 kept", 64'(e[47:0]), 64'(bmac(1)));
    rd(1, e); chk("R3 oldest way replaced", 64'(e[47:0]), 64'(bmac(5)));
    rd(2, e); chk("R3 way2 kept", 64'(e[47:0]), 64'(bmac(3)));
    rd(3, e); chk("R3 way3 kept", 64'(e[47:0]), 64'(bmac(4)));

    // R8 with the default one-minute limit (R1)
    idle(200);
    for (int i = 0; i < WAYS; i++) begin
      rd(i, e);
      chk("R8 stale entry swept (R1 default limit)", 64'(e[63]), 64'd0);
    end

    // R7: six minutes keeps an entry alive, clamp of 0 brings it back to one
    set_minutes(3'd6);
    send(C, 4'd3);
    idle(400);
    rd(8, e);
    chk("R7 six-minute limit keeps entry", 64'(e[63]), 64'd1);
    set_minutes(3'd0);
    idle(40);
    rd(8, e);
    chk("R7 zero clamps to one minute", 64'(e[63]), 64'd0);
    set_minutes(3'd7);
    send(D, 4'd4);
    idle(400);
    rd(12, e);
    chk("R7 seven clamps to six minutes", 64'(e[63]), 64'd1);
    set_minutes(3'd1);
    idle(40);

    // R9: write lands two edges after the queueing edge
    send(G, 4'd6);
    rd(16, e);
    chk("R9 not yet written after one edge", 64'(e[63]), 64'd0);
    rd(16, e);
    chk("R9 written after two edges", 64'(e[63]), 64'd1);
    idle(4);

    // R10: twelve back-to-back observations overflow the queue three times
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      obs_valid = 1'b1; obs_mac = emac(i); obs_port = 4'(i);
    end
    @(negedge clk);
    obs_valid = 1'b0;
    idle(12);
    chk("R10 three drops", 64'(drop_count), 64'd3);
    find(emac(7), ix);
    chk("R10 dropped observation absent", 64'(ix), 64'(-1));
    find(emac(8), ix);
    chk("R10 accepted observation present", 64'(ix >= 0), 64'd1);

    // R6: steady tick rate and wrap
    @(negedge clk);
    #1 t0 = cur_time;
    idle(5 * TD);
    #1 chk("R6 five ticks", 64'(cur_time), 64'(t0 + 10'd5));
    while (cur_time != 10'd1023) @(negedge clk);
    idle(TD);
    #1 chk("R6 wrap to zero", 64'(cur_time), 64'd0);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule